// File: doc/BRIEF.md
# DSP Shifter with Overflow Flags

This unit is the shift stage of a DSP datapath. One 32-bit operand passes through it each valid cycle. It can work as a single 16-bit half, as two independent 16-bit lanes, or as one 32-bit word. The shift amount has two possible sources. One is a signed count carried in the low six bits of a count register. The other is a five-bit immediate with its own encoding. A positive amount shifts left. Zero or a negative amount shifts right arithmetically.

The unit checks every left shift for a sign change. When the sign bit of the result differs from the sign bit of the input, the shift has overflowed. An overflow raises the overflow flag V and the sticky flag VS. VS stays high until the surrounding pipeline clears it. An optional saturating variant clamps an overflowing lane to the largest value of the input's sign. In single-half mode the 16-bit result goes into one half of the destination word, and the other half keeps the value supplied on `opDst`. The result and the flags are registered, so they appear one clock after the operation is presented.

Top module: `dsp_shift_unit`

## Requirements
- R1: While `rst_n` is low, `result`, `flagV` and `flagVS` are 0.
- R2: With `useImm`=0, the amount is `regCount` read as a signed 6-bit value (-32..31). A value of 1..31 shifts left by that amount. A value of 0 or below shifts right arithmetically by its negation.
- R3: With `useImm`=1, an `immCount` above 16 shifts left by 16 minus `immCount[3:0]`. An `immCount` of 0..16 shifts right arithmetically by `immCount`.
- R4: For every valid operation, `flagV` is recomputed. It is 1 only if a left shift changed the sign bit of a lane (bit 15 of a 16-bit lane, bit 31 of the word). A right shift always leaves `flagV` at 0.
- R5: `flagVS` is set by any valid operation that sets `flagV`. It then stays at 1 until a cycle in which `vsClear` is 1 and no overflowing operation is presented. If both happen in the same cycle, the set wins.
- R6: With `mode`=2'b01, bits 15:0 and bits 31:16 of `opA` are shifted separately by the same amount and repacked as {high, low}. `flagV` is 1 if either lane overflowed.
- R7: With `mode`=2'b00, the source is `opA[31:16]` when `srcHi`=1 and `opA[15:0]` otherwise. The 16-bit result goes to bits 31:16 when `dstHi`=1 and to bits 15:0 otherwise. The other half of `result` is taken from `opDst`.
- R8: With `mode`=2'b10 or 2'b11, the full 32-bit word is shifted, and bit 31 is the sign bit used for the overflow test.
- R9: With `satEn`=1, a lane that overflows is clamped. A non-negative input gives 0x7FFF (or 0x7FFFFFFF for the word), and a negative input gives 0x8000 (or 0x80000000). With `satEn`=0, the bits shifted out are simply lost.
- R10: A right shift by at least the lane width fills the lane with copies of its sign bit. A left shift by at least the lane width leaves zero before the overflow test.
- R11: `result` and `flagV` change only on a clock edge where `inValid` is 1, and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Presents an operation this cycle |
| useImm | input | 1 | 1 selects `immCount`, 0 selects `regCount` |
| regCount | input | 6 | Signed count taken from a count register |
| immCount | input | 5 | Immediate count field |
| mode | input | 2 | 00 half, 01 dual lane, 10/11 full word |
| satEn | input | 1 | Saturate on left-shift overflow |
| srcHi | input | 1 | Half mode: choose the high half of `opA` |
| dstHi | input | 1 | Half mode: write the high half of `result` |
| vsClear | input | 1 | Synchronous clear of the sticky flag |
| opA | input | 32 | Operand |
| opDst | input | 32 | Current destination value, merged in half mode |
| result | output | 32 | Registered shift result |
| flagV | output | 1 | Overflow of the last operation |
| flagVS | output | 1 | Sticky overflow |

## Verification
Internal state lives in only three places: the result register, the V register and the sticky register. A fault in any of them shows at the ports on the clock after the operation that exposes it. The bench compares against its model every cycle, so a wrong count decode, a swapped lane, a lost preserved half or a missed clamp appears as a mismatch on the very next sample. A sticky flag that fails to hold, or a clear that arrives late, first shows when a later non-overflowing operation or an idle cycle leaves V and VS disagreeing with the model. The directed sequence forces that situation right after each overflow.

// File: rtl/dsp_shift_pkg.sv
package dsp_shift_pkg;
  parameter int ShiftAmtW = 6;

  typedef enum logic [1:0] {
    MODE_HALF     = 2'b00,
    MODE_VEC      = 2'b01,
    MODE_WORD     = 2'b10,
    MODE_WORD_ALT = 2'b11
  } shiftMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 load;
    logic                 left;
    logic [ShiftAmtW-1:0] amt;
    logic                 sat;
    logic                 srcHi;
    logic                 dstHi;
    shiftMode_e           mode;
    logic                 clearSticky;
  } shiftCtrl_t;
endpackage

// File: rtl/dsp_shift_ctrl.sv
module dsp_shift_ctrl
  import dsp_shift_pkg::*;
#(
  parameter int LaneW = 16,
  parameter int CntW  = 6,
  parameter int ImmW  = 5
) (
  input  logic            inValid,
  input  logic            useImm,
  input  logic [CntW-1:0] regCount,
  input  logic [ImmW-1:0] immCount,
  input  logic [1:0]      mode,
  input  logic            satEn,
  input  logic            srcHi,
  input  logic            dstHi,
  input  logic            vsClear,
  output shiftCtrl_t      ctrl
);
  localparam int LowW = $clog2(LaneW);

  logic [CntW-1:0] negCount;
  logic            regPositive;
  logic            immLeft;

  assign negCount    = -regCount;
  assign regPositive = !regCount[CntW-1] && (regCount != '0);
  assign immLeft     = immCount > ImmW'(LaneW);

  always_comb begin
    ctrl             = '0;
    ctrl.load        = inValid;
    ctrl.sat         = satEn;
    ctrl.srcHi       = srcHi;
    ctrl.dstHi       = dstHi;
    ctrl.mode        = shiftMode_e'(mode);
    ctrl.clearSticky = vsClear;
    if (useImm) begin
      ctrl.left = immLeft;
      if (immLeft)
        ctrl.amt = ShiftAmtW'(LaneW) - ShiftAmtW'(immCount[LowW-1:0]);
      else
        ctrl.amt = ShiftAmtW'(immCount);
    end else begin
      ctrl.left = regPositive;
      ctrl.amt  = regPositive ? ShiftAmtW'(regCount) : ShiftAmtW'(negCount);
    end
  end
endmodule

// File: rtl/dsp_shift_lane.sv
module dsp_shift_lane #(
  parameter int W    = 16,
  parameter int AmtW = 6
) (
  input  logic [W-1:0]    din,
  input  logic            left,
  input  logic [AmtW-1:0] amt,
  input  logic            sat,
  output logic [W-1:0]    dout,
  output logic            ovf
);
  logic         signBit;
  logic         wide;
  logic [W-1:0] shl;
  logic [W-1:0] shr;

  assign signBit = din[W-1];
  assign wide    = amt >= AmtW'(W);

  always_comb begin
    if (wide) begin
      shl = '0;
      shr = {W{signBit}};
    end else begin
      shl = din << amt;
      shr = W'($signed(din) >>> amt);
    end
    ovf = left && (shl[W-1] != signBit);
    if (!left)
      dout = shr;
    else if (ovf && sat)
      dout = signBit ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else
      dout = shl;
  end
endmodule

// File: rtl/dsp_shift_dp.sv
module dsp_shift_dp
  import dsp_shift_pkg::*;
#(
  parameter int WordW = 32,
  parameter int LaneW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  shiftCtrl_t       ctrl,
  input  logic [WordW-1:0] opA,
  input  logic [WordW-1:0] opDst,
  output logic [WordW-1:0] result,
  output logic             flagV,
  output logic             flagVS
);
  localparam int NumLanes = WordW / LaneW;

  logic [NumLanes-1:0][LaneW-1:0] laneIn;
  logic [NumLanes-1:0][LaneW-1:0] laneOut;
  logic [NumLanes-1:0]            laneOvf;
  logic [WordW-1:0]               wordOut;
  logic                           wordOvf;
  logic [WordW-1:0]               nextRes;
  logic                           nextOvf;
  logic [WordW-1:0]               resReg;
  logic                           vReg;
  logic                           vsReg;

  for (genvar g = 0; g < NumLanes; g++) begin : gLane
    if (g == 0) begin : gSel
      assign laneIn[g] = (ctrl.mode == MODE_HALF && ctrl.srcHi) ?
                         opA[LaneW +: LaneW] : opA[0 +: LaneW];
    end else begin : gDirect
      assign laneIn[g] = opA[g*LaneW +: LaneW];
    end
    dsp_shift_lane #(.W(LaneW), .AmtW(ShiftAmtW)) uLane (
      .din (laneIn[g]),
      .left(ctrl.left),
      .amt (ctrl.amt),
      .sat (ctrl.sat),
      .dout(laneOut[g]),
      .ovf (laneOvf[g])
    );
  end

  dsp_shift_lane #(.W(WordW), .AmtW(ShiftAmtW)) uWord (
    .din (opA),
    .left(ctrl.left),
    .amt (ctrl.amt),
    .sat (ctrl.sat),
    .dout(wordOut),
    .ovf (wordOvf)
  );

  always_comb begin
    nextRes = wordOut;
    nextOvf = wordOvf;
    unique case (ctrl.mode)
      MODE_HALF: begin
        nextRes = opDst;
        nextOvf = laneOvf[0];
        if (ctrl.dstHi) nextRes[LaneW +: LaneW] = laneOut[0];
        else            nextRes[0 +: LaneW]     = laneOut[0];
      end
      MODE_VEC: begin
        nextRes = laneOut;
        nextOvf = |laneOvf;
      end
      default: begin
        nextRes = wordOut;
        nextOvf = wordOvf;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resReg <= '0;
      vReg   <= 1'b0;
      vsReg  <= 1'b0;
    end else begin
      if (ctrl.load) begin
        resReg <= nextRes;
        vReg   <= nextOvf;
      end
      if (ctrl.load && nextOvf) vsReg <= 1'b1;
      else if (ctrl.clearSticky) vsReg <= 1'b0;
    end
  end

  assign result = resReg;
  assign flagV  = vReg;
  assign flagVS = vsReg;
endmodule

// File: rtl/dsp_shift_unit.sv
module dsp_shift_unit
  import dsp_shift_pkg::*;
#(
  parameter int WordW = 32,
  parameter int CntW  = 6,
  parameter int ImmW  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic             useImm,
  input  logic [CntW-1:0]  regCount,
  input  logic [ImmW-1:0]  immCount,
  input  logic [1:0]       mode,
  input  logic             satEn,
  input  logic             srcHi,
  input  logic             dstHi,
  input  logic             vsClear,
  input  logic [WordW-1:0] opA,
  input  logic [WordW-1:0] opDst,
  output logic [WordW-1:0] result,
  output logic             flagV,
  output logic             flagVS
);
  localparam int LaneW = WordW / 2;

  shiftCtrl_t ctrl;

  dsp_shift_ctrl #(.LaneW(LaneW), .CntW(CntW), .ImmW(ImmW)) uCtrl (
    .inValid (inValid),
    .useImm  (useImm),
    .regCount(regCount),
    .immCount(immCount),
    .mode    (mode),
    .satEn   (satEn),
    .srcHi   (srcHi),
    .dstHi   (dstHi),
    .vsClear (vsClear),
    .ctrl    (ctrl)
  );

  dsp_shift_dp #(.WordW(WordW), .LaneW(LaneW)) uDp (
    .clk   (clk),
    .rst_n (rst_n),
    .ctrl  (ctrl),
    .opA   (opA),
    .opDst (opDst),
    .result(result),
    .flagV (flagV),
    .flagVS(flagVS)
  );
endmodule

// File: rtl/dsp_shift_checker.sv
module dsp_shift_checker #(
  parameter int WordW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inValid,
  input logic [1:0]       mode,
  input logic             dstHi,
  input logic             vsClear,
  input logic [WordW-1:0] opDst,
  input logic [WordW-1:0] result,
  input logic             flagV,
  input logic             flagVS
);
  localparam int HalfW = WordW / 2;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (result == '0 && !flagV && !flagVS));

  assert_sticky_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flagV) |-> flagVS);

  assert_sticky_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flagVS && !vsClear) |=> flagVS);

  assert_sticky_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vsClear && !inValid) |=> !flagVS);

  assert_half_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && mode == 2'b00 && !dstHi) |=>
      result[WordW-1:HalfW] == $past(opDst[WordW-1:HalfW]));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> ($stable(result) && $stable(flagV)));
endmodule

bind dsp_shift_unit dsp_shift_checker #(.WordW(WordW)) uChecker (
  .clk    (clk),
  .rst_n  (rst_n),
  .inValid(inValid),
  .mode   (mode),
  .dstHi  (dstHi),
  .vsClear(vsClear),
  .opDst  (opDst),
  .result (result),
  .flagV  (flagV),
  .flagVS (flagVS)
);

// File: tb/tb_dsp_shift_unit.sv
`timescale 1ns/1ps
module tb_dsp_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        useImm = 1'b0;
  logic [5:0]  regCount = '0;
  logic [4:0]  immCount = '0;
  logic [1:0]  mode = '0;
  logic        satEn = 1'b0;
  logic        srcHi = 1'b0;
  logic        dstHi = 1'b0;
  logic        vsClear = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opDst = '0;
  logic [31:0] result;
  logic        flagV;
  logic        flagVS;

  int    checks = 0;
  int    failures = 0;
  bit    armed = 0;
  bit    done = 0;
  string curReq = "R1";
  string expTag = "R1";
  longint expRes = 0;
  bit    expV = 0;
  bit    expVS = 0;

  always #2 clk = ~clk;

  dsp_shift_unit dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .useImm(useImm),
    .regCount(regCount), .immCount(immCount), .mode(mode), .satEn(satEn),
    .srcHi(srcHi), .dstHi(dstHi), .vsClear(vsClear), .opA(opA),
    .opDst(opDst), .result(result), .flagV(flagV), .flagVS(flagVS)
  );

  // shift amount: positive = left, otherwise right by the negation
  function automatic int refAmount();
    int c;
    if (useImm) return (immCount > 16) ? (16 - int'(immCount[3:0])) : -int'(immCount);
    c = int'(regCount);
    if (c >= 32) c = c - 64;
    return c;
  endfunction

  function automatic void laneRef(input longint x, input int w, input int sh,
                                  input bit sat, output longint r, output bit ov);
    longint m = (longint'(1) << w) - 1;
    bit neg = ((x >> (w - 1)) & 1) == 1;
    longint sv = neg ? (x - (longint'(1) << w)) : x;
    ov = 0;
    if (sh > 0) begin
      r = (sv <<< sh) & m;
      ov = (((r >> (w - 1)) & 1) == 1) != neg;
      if (sat && ov) r = neg ? (longint'(1) << (w - 1)) : ((longint'(1) << (w - 1)) - 1);
    end else begin
      r = (sv >>> (-sh)) & m;
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    longint r0, r1;
    bit o0, o1, ov;
    int sh;
    if (!rst_n) begin
      expRes = 0; expV = 0; expVS = 0; expTag = "R1";
    end else begin
      ov = 0;
      if (inValid) begin
        sh = refAmount();
        if (mode == 2'b00) begin
          laneRef(srcHi ? longint'(opA[31:16]) : longint'(opA[15:0]), 16, sh, satEn, r0, o0);
          expRes = dstHi ? ((r0 << 16) | longint'(opDst[15:0]))
                         : ((longint'(opDst[31:16]) << 16) | r0);
          ov = o0;
        end else if (mode == 2'b01) begin
          laneRef(longint'(opA[15:0]), 16, sh, satEn, r0, o0);
          laneRef(longint'(opA[31:16]), 16, sh, satEn, r1, o1);
          expRes = (r1 << 16) | r0;
          ov = o0 | o1;
        end else begin
          laneRef(longint'(opA), 32, sh, satEn, r0, o0);
          expRes = r0;
          ov = o0;
        end
        expV = ov;
      end
      if (inValid && ov) expVS = 1;
      else if (vsClear) expVS = 0;
      expTag = curReq;
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      checks++;
      if (longint'(result) != expRes || flagV != expV || flagVS != expVS) begin
        failures++;
        $display("FAIL %s: result=%h V=%0d VS=%0d expected result=%h V=%0d VS=%0d",
                 expTag, result, flagV, flagVS, expRes[31:0], expV, expVS);
      end
    end
  end

  task automatic doOp(input string tag, input logic [1:0] md, input bit imm,
                      input logic [5:0] rc, input logic [4:0] ic, input logic [31:0] a,
                      input logic [31:0] d, input bit sat, input bit sh, input bit dh,
                      input bit clr);
    @(negedge clk);
    curReq = tag; inValid = 1; mode = md; useImm = imm; regCount = rc;
    immCount = ic; opA = a; opDst = d; satEn = sat; srcHi = sh; dstHi = dh; vsClear = clr;
  endtask

  task automatic idle(input string tag, input bit clr);
    @(negedge clk);
    curReq = tag; inValid = 0; vsClear = clr;
    opA = ~opA; regCount = regCount + 6'd5; mode = mode + 2'd1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    armed = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R2 register count: left, right, most negative
    doOp("R2", 2'b00, 0, 6'd3, 0, 32'h0000_0123, 32'hAAAA_0000, 0, 0, 0, 0);
    doOp("R2", 2'b00, 0, 6'h3C, 0, 32'h0000_8100, 32'h5555_5555, 0, 0, 0, 0);
    doOp("R2", 2'b10, 0, 6'h20, 0, 32'h8000_0001, 0, 0, 0, 0, 0);
    doOp("R2", 2'b10, 0, 6'd0, 0, 32'h1234_5678, 0, 0, 0, 0, 0);
    // R3 immediate decode
    doOp("R3", 2'b00, 1, 0, 5'd20, 32'h0000_0003, 0, 0, 0, 0, 0);
    doOp("R3", 2'b00, 1, 0, 5'd16, 32'h0000_9000, 0, 0, 0, 0, 0);
    doOp("R3", 2'b01, 1, 0, 5'd17, 32'h0001_0000, 0, 0, 0, 0, 0);
    doOp("R3", 2'b01, 1, 0, 5'd5, 32'hF000_0F00, 0, 0, 0, 0, 0);
    // R4 overflow then a clean shift and a right shift
    doOp("R4", 2'b00, 0, 6'd1, 0, 32'h0000_4000, 0, 0, 0, 0, 0);
    doOp("R4", 2'b00, 0, 6'd1, 0, 32'h0000_2000, 0, 0, 0, 0, 0);
    doOp("R4", 2'b10, 0, 6'h3F, 0, 32'h8000_0000, 0, 0, 0, 0, 0);
    // R5 sticky: hold, clear, set-wins-over-clear
    idle("R5", 0);
    idle("R5", 1);
    idle("R5", 0);
    doOp("R5", 2'b10, 0, 6'd2, 0, 32'h2000_0000, 0, 0, 0, 0, 1);
    doOp("R5", 2'b10, 0, 6'd1, 0, 32'h0000_0001, 0, 0, 0, 0, 0);
    idle("R5", 1);
    // R6 vector: only the high lane overflows, then only the low lane
    doOp("R6", 2'b01, 0, 6'd2, 0, 32'h3000_0101, 0, 0, 0, 0, 0);
    doOp("R6", 2'b01, 0, 6'd2, 0, 32'h0101_C000, 0, 0, 0, 0, 1);
    // R7 half-mode source and destination selection
    doOp("R7", 2'b00, 0, 6'd4, 0, 32'h0123_FFFF, 32'hDEAD_BEEF, 0, 1, 1, 0);
    doOp("R7", 2'b00, 0, 6'h3E, 0, 32'h8642_0000, 32'hCAFE_F00D, 0, 1, 0, 0);
    // R8 word sign bit 31
    doOp("R8", 2'b10, 0, 6'd1, 0, 32'h4000_0000, 0, 0, 0, 0, 1);
    doOp("R8", 2'b11, 0, 6'd1, 0, 32'h0000_4000, 0, 0, 0, 0, 1);
    // R9 saturation per lane and on the word
    doOp("R9", 2'b01, 0, 6'd3, 0, 32'h9000_2000, 0, 1, 0, 0, 0);
    doOp("R9", 2'b10, 0, 6'd4, 0, 32'h1000_0000, 0, 1, 0, 0, 0);
    doOp("R9", 2'b10, 0, 6'd4, 0, 32'hA000_0000, 0, 1, 0, 0, 0);
    doOp("R9", 2'b00, 1, 0, 5'd31, 32'h0000_8001, 0, 1, 0, 0, 0);
    // R10 wide shifts
    doOp("R10", 2'b00, 0, 6'h2C, 0, 32'h0000_8ABC, 32'h1111_1111, 0, 0, 0, 0);
    doOp("R10", 2'b01, 0, 6'd20, 0, 32'h0001_8000, 0, 0, 0, 0, 0);
    doOp("R10", 2'b10, 0, 6'h20, 0, 32'h7FFF_FFFF, 0, 0, 0, 0, 0);
    // R11 idle cycles with changing inputs
    idle("R11", 0);
    idle("R11", 0);
    // mixed stimulus
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 8) == 0) idle("R11", ($urandom % 4) == 0);
      else doOp("R4", 2'($urandom), 1'($urandom), 6'($urandom), 5'($urandom),
                $urandom, $urandom, 1'($urandom), 1'($urandom), 1'($urandom),
                ($urandom % 5) == 0);
    end
    idle("R11", 0);
    @(negedge clk);
    @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule